// File: doc/BRIEF.md
# Valid-Qualified Stream Alignment Delay

This block keeps an unprocessed packet stream in step with a processing branch whose latency is a fixed number of beats. Each beat has a 16-bit pixel word and start-of-packet and end-of-packet markers. A beat only counts when its valid flag is high. The block stores those beats in a chain of `DEPTH` registers. The pixel word and both markers sit in one stage word, so they always move together.

The chain moves only when a beat is accepted, which means the input valid is high and the downstream ready is high. When the chain moves, the beat in its last stage leaves the block. That same cycle, the new beat enters the first stage. The result is a delay counted in accepted beats, not in clock cycles:

- Beat k comes out in the cycle that beat k+`DEPTH` is accepted.
- Cycles with no valid input do not move the chain.
- Cycles with the downstream ready low do not move the chain. During these cycles the contents are held.
- The output valid is produced inside the block. It is high only when the word at the output is a real stored beat that leaves in that cycle.
- The upstream ready is the downstream ready passed straight through.

Top module: `stream_align_delay`

## Requirements
- R1: `up_ready` always equals `ds_ready` in the same cycle. There is no register between them.
- R2: A beat is accepted only in a cycle where `rst_n`, `in_valid` and `ds_ready` are all high. The stored chain contents change only at a clock edge that ends such a cycle.
- R3: Count accepted beats from 0 after reset. In the cycle that beat number k+DEPTH is accepted, the outputs present beat number k and `out_valid` is high. DEPTH defaults to 15.
- R4: `out_sop` and `out_eop` leave the block with the same beat whose pixel word they came in with. The marker pattern of the output stream equals that of the input stream, beat for beat.
- R5: `out_valid` is low in every cycle where `ds_ready` is low.
- R6: `out_valid` is high only in a cycle that accepts a beat while the chain already holds DEPTH beats. After reset, the first DEPTH accepted beats produce no output beat.
- R7: Holding `ds_ready` low for any number of cycles loses no stored beat and duplicates none. This holds even while `in_valid` stays high. The sequence resumes in order once ready returns.
- R8: Cycles with `in_valid` low and `ds_ready` high store nothing. They only delay the later output sequence and never insert a beat into it.
- R9: `rst_n` is a synchronous, active-low reset. It empties the chain and keeps `out_valid` low while it is low. Beats stored before the reset never reach the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 16 | Incoming pixel word |
| in_valid | input | 1 | Incoming beat qualifier |
| in_sop | input | 1 | Incoming start-of-packet marker |
| in_eop | input | 1 | Incoming end-of-packet marker |
| ds_ready | input | 1 | Downstream ready |
| up_ready | output | 1 | Upstream ready, equal to ds_ready |
| out_data | output | 16 | Delayed pixel word |
| out_valid | output | 1 | Delayed beat qualifier |
| out_sop | output | 1 | Delayed start-of-packet marker |
| out_eop | output | 1 | Delayed end-of-packet marker |

## Verification
Some rules are checked on every cycle:

- the ready pass-through;
- no valid output while ready is low;
- no output valid without an input valid;
- no output before the chain holds DEPTH beats;
- output words held steady while nothing is accepted.

Other properties need the bench's scenarios: the exact beat order and marker positions under random gaps and backpressure, survival of beats through long stalls, and the removal of pre-reset contents. Each of these depends on comparing whole sequences against a reference history.

// File: rtl/sad_pkg.sv
// Package: shared beat type for the stream alignment delay.
// Assumes one fixed pixel width across the block; markers ride beside it.
package sad_pkg;
    localparam int PIX_W = 16;

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic             sop;
        logic             eop;
    } beat_t;

    localparam int BEAT_W = $bits(beat_t);
endpackage

// File: rtl/sad_stage.sv
// Module: sad_stage
// One slot of the delay chain: a packed beat word plus an occupancy flag.
// Assumes the caller raises adv only when a real beat is being accepted;
// the word has no reset because the occupancy flag marks it as junk.
module sad_stage
    import sad_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    input  beat_t d_word,
    input  logic  d_occ,
    output beat_t q_word,
    output logic  q_occ
);
    // Word register: loads the neighbour's word on each accepted beat.
    always_ff @(posedge clk) begin
        if (adv) begin
            q_word <= d_word;
        end
    end

    // Occupancy flag: cleared by reset, follows the neighbour on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_occ <= 1'b0;
        end else if (adv) begin
            q_occ <= d_occ;
        end
    end
endmodule

// File: rtl/sad_chain.sv
// Module: sad_chain
// DEPTH stages in series, all sharing one advance enable.
// Assumes DEPTH >= 1; slot 0 is fed directly by the incoming beat.
module sad_chain
    import sad_pkg::*;
#(
    parameter int DEPTH = 15
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    input  beat_t head_word,
    input  logic  head_occ,
    output beat_t tail_word,
    output logic  tail_occ
);
    beat_t           word_w [DEPTH+1];
    logic [DEPTH:0]  occ_w;

    // Entry tap: the incoming beat feeds the first slot.
    always_comb begin
        word_w[0] = head_word;
        occ_w[0]  = head_occ;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        sad_stage u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv    (adv),
            .d_word (word_w[g]),
            .d_occ  (occ_w[g]),
            .q_word (word_w[g+1]),
            .q_occ  (occ_w[g+1])
        );
    end

    assign tail_word = word_w[DEPTH];
    assign tail_occ  = occ_w[DEPTH];
endmodule

// File: rtl/sad_ctrl.sv
// Module: sad_ctrl
// Acceptance and output qualification for the delay chain.
// Assumes the downstream takes the output beat in any cycle ready is high,
// so leaving a beat and accepting a new one happen in the same cycle.
module sad_ctrl (
    input  logic rst_n,
    input  logic in_valid,
    input  logic ds_ready,
    input  logic tail_occ,
    output logic adv,
    output logic up_ready,
    output logic out_valid
);
    // Accept decision: only a qualified beat under ready moves the chain.
    always_comb begin
        up_ready  = ds_ready;
        adv       = rst_n & in_valid & ds_ready;
        out_valid = adv & tail_occ;
    end
endmodule

// File: rtl/stream_align_delay.sv
// Module: stream_align_delay (top)
// Delays a valid-qualified packet stream by DEPTH accepted beats so that it
// lines up with a fixed-latency processing branch. The chain stalls whenever
// the downstream is not ready and ignores idle cycles.
// Assumes the processing branch also advances once per accepted beat.
module stream_align_delay
    import sad_pkg::*;
#(
    parameter int DEPTH = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic             ds_ready,
    output logic             up_ready,
    output logic [PIX_W-1:0] out_data,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop
);
    beat_t in_word;
    beat_t tail_word;
    logic  tail_occ;
    logic  adv;

    // Pack the incoming beat so pixel and markers share one stage word.
    always_comb begin
        in_word.pix = in_data;
        in_word.sop = in_sop;
        in_word.eop = in_eop;
    end

    sad_ctrl u_ctrl (
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .ds_ready  (ds_ready),
        .tail_occ  (tail_occ),
        .adv       (adv),
        .up_ready  (up_ready),
        .out_valid (out_valid)
    );

    sad_chain #(.DEPTH(DEPTH)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .head_word (in_word),
        .head_occ  (in_valid),
        .tail_word (tail_word),
        .tail_occ  (tail_occ)
    );

    // Unpack the beat leaving the last slot.
    always_comb begin
        out_data = tail_word.pix;
        out_sop  = tail_word.sop;
        out_eop  = tail_word.eop;
    end
endmodule

// File: rtl/sad_checker.sv
// Module: sad_checker
// Cycle-level rules for stream_align_delay, attached by bind.
// Keeps its own count of stored beats to check the fill rule.
module sad_checker #(
    parameter int DEPTH = 15
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        ds_ready,
    input logic        up_ready,
    input logic        out_valid,
    input logic [15:0] out_data,
    input logic        out_sop,
    input logic        out_eop
);
    int held;

    // Stored-beat tally: grows on accepts that produce no output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 0;
        end else if (in_valid && ds_ready && !out_valid && held <= DEPTH) begin
            held <= held + 1;
        end
    end

    p_ready_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready == ds_ready);

    p_hold_unaccepted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && ds_ready) |=> ($stable(out_data) && $stable(out_sop) && $stable(out_eop)));

    p_no_overfill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        held <= DEPTH);

    p_no_valid_stalled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_ready |-> !out_valid);

    p_full_before_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (held == DEPTH && in_valid));
endmodule

bind stream_align_delay sad_checker #(.DEPTH(DEPTH)) u_sad_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .ds_ready  (ds_ready),
    .up_ready  (up_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
);

// File: tb/tb_stream_align_delay.sv
// Directed bench for stream_align_delay with a history-based reference.
module tb_stream_align_delay;
    localparam int DEPTH = 15;
    localparam int HIST  = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic        ds_ready = 1'b0;
    logic        up_ready, out_valid, out_sop, out_eop;
    logic [15:0] out_data;

    int checks = 0;
    int errors = 0;
    int acc = 0;
    int outs = 0;
    logic [17:0] hist [HIST];
    logic [15:0] seq = 16'h1000;

    always #2 clk = ~clk;

    stream_align_delay #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_sop(in_sop), .in_eop(in_eop), .ds_ready(ds_ready),
        .up_ready(up_ready), .out_data(out_data), .out_valid(out_valid),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check settled outputs, then model the edge.
    task automatic step(input logic rn, input logic v, input logic [15:0] d,
                        input logic s, input logic e, input logic r);
        logic ev;
        @(negedge clk);
        rst_n = rn; in_valid = v; in_data = d; in_sop = s; in_eop = e; ds_ready = r;
        #1;
        ev = rn && v && r && (acc >= DEPTH);
        chk("R1 up_ready", {31'd0, up_ready}, {31'd0, r});
        if (!r) chk("R5 no valid while stalled", {31'd0, out_valid}, 32'd0);
        if (!rn) chk("R9 valid low in reset", {31'd0, out_valid}, 32'd0);
        chk("R6 out_valid", {31'd0, out_valid}, {31'd0, ev});
        if (ev && out_valid) begin
            chk("R3 delayed pixel", {16'd0, out_data}, {16'd0, hist[(acc-DEPTH)%HIST][17:2]});
            chk("R4 markers with pixel", {30'd0, out_sop, out_eop}, {30'd0, hist[(acc-DEPTH)%HIST][1:0]});
            outs++;
        end
        if (!rn) acc = 0;
        else if (v && r) begin
            hist[acc%HIST] = {d, s, e};
            acc++;
        end
    endtask

    // Send one packet of len beats with optional random gaps and stalls.
    task automatic send_pkt(input int len, input int gap_pct, input int stall_pct);
        int i = 0;
        while (i < len) begin
            logic r = (($urandom % 100) >= stall_pct);
            if (($urandom % 100) < gap_pct) begin
                step(1'b1, 1'b0, 16'hDEAD, 1'b0, 1'b0, r);
            end else begin
                step(1'b1, 1'b1, seq, (i == 0), (i == len-1), r);
                if (r) begin
                    i++;
                    seq = seq + 16'd3;
                end
            end
        end
    endtask

    task automatic do_reset();
        step(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_reset_state();
        do_reset();
        step(1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        chk("R9 empty after reset", {31'd0, out_valid}, 32'd0);
        step(1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_continuous();
        do_reset();
        for (int p = 0; p < 6; p++) send_pkt(7 + p, 0, 0);
        chk("R3 output count continuous", outs, 0 + (acc - DEPTH));
    endtask

    task automatic t_gaps();
        int o0;
        do_reset();
        o0 = outs;
        for (int p = 0; p < 20; p++) send_pkt(1 + (p % 9), 40, 0);
        chk("R8 gaps add no beats", outs - o0, acc - DEPTH);
    endtask

    task automatic t_backpressure();
        int o0;
        do_reset();
        o0 = outs;
        for (int p = 0; p < 20; p++) send_pkt(2 + (p % 11), 25, 35);
        chk("R7 no loss under stalls", outs - o0, acc - DEPTH);
    endtask

    task automatic t_long_stall();
        int o0;
        do_reset();
        send_pkt(DEPTH + 3, 0, 0);
        o0 = outs;
        for (int c = 0; c < 40; c++) step(1'b1, 1'b1, 16'hBEEF, 1'b1, 1'b1, 1'b0);
        chk("R7 nothing out during stall", outs - o0, 0);
        send_pkt(DEPTH, 0, 0);
        chk("R7 resumed in order", outs - o0, DEPTH);
    endtask

    task automatic t_idle_hold();
        int o0;
        do_reset();
        send_pkt(DEPTH, 0, 0);
        o0 = outs;
        for (int c = 0; c < 30; c++) step(1'b1, 1'b0, 16'h5555, 1'b1, 1'b1, 1'b1);
        chk("R8 idle stores nothing", outs - o0, 0);
        send_pkt(4, 0, 0);
        chk("R2 chain moves only on accept", outs - o0, 4);
    endtask

    task automatic t_reset_flush();
        int o0;
        do_reset();
        send_pkt(DEPTH + 5, 0, 0);
        do_reset();
        o0 = outs;
        send_pkt(DEPTH, 0, 0);
        chk("R9 old beats flushed", outs - o0, 0);
        send_pkt(3, 0, 0);
        chk("R6 output starts after fill", outs - o0, 3);
    endtask

    initial begin
        t_reset_state();
        t_continuous();
        t_gaps();
        t_backpressure();
        t_long_stall();
        t_idle_hold();
        t_reset_flush();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule